// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block reduces how often a packet engine interrupts its host. It counts finished packets down from a programmed threshold and raises a completion-interrupt set pulse only when the count runs out. A one-shot delay timer also restarts on each completed packet. If traffic stops before the threshold is reached, the timer expires, raises a delay-interrupt set pulse and rearms the packet counter. Both paths share the one counter.

The block takes the whole control word and extracts the threshold and delay fields itself. A write strobe marks every control-register write. A tick enable sets the timer rate. The block drives only set pulses and the live counter and timer values. The status register, the interrupt masks and the clearing of pending interrupts all live outside it.

Top module: `irq_coalescer`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `coal_cnt` is 1, `delay_cnt` is 0, and `ioc_set` and `dly_set` are 0.
- R2: The packet threshold is `ctrl_word[23:16]` and the delay value is `ctrl_word[31:24]`. Bits 15:0 have no effect.
- R3: Each `pkt_done` cycle lowers `coal_cnt` by one. A `pkt_done` while `coal_cnt` is 1 pulses `ioc_set` in the next cycle and reloads `coal_cnt` with the threshold.
- R4: A threshold field of 0 behaves as 1, so every completion pulses `ioc_set`.
- R5: A `pkt_done` with a nonzero delay field loads `delay_cnt` with that delay. This applies even when the timer is already counting.
- R6: A `pkt_done` with a delay field of 0 leaves the timer untouched, and that completion never causes a `dly_set`.
- R7: `delay_cnt` decrements only in cycles with `tick_en` high. It holds at 0 and does not reload itself.
- R8: When `delay_cnt` ticks from 1 to 0, `dly_set` pulses in the next cycle and `coal_cnt` is reloaded with the threshold.
- R9: A `ctrl_wr` cycle reloads `coal_cnt` with the threshold. It takes priority over a completion or an expiry in the same cycle, and then no `ioc_set` occurs.
- R10: A completion with a nonzero delay in the same cycle as a timer expiry wins. The timer restarts, `dly_set` stays low, and `coal_cnt` decrements.
- R11: `ioc_set` and `dly_set` last a single cycle for each event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_done | input | 1 | One-cycle packet-completion pulse |
| tick_en | input | 1 | Timer decrement enable |
| ctrl_wr | input | 1 | Strobe on every control-register write |
| ctrl_word | input | CTRL_W (32) | Current control-register value |
| ioc_set | output | 1 | Sets the completion interrupt |
| dly_set | output | 1 | Sets the delay interrupt |
| coal_cnt | output | CNT_W (8) | Live packet counter |
| delay_cnt | output | DLY_W (8) | Live delay timer |

## Verification
The bench builds the block with its default parameters: a 32-bit control word, 8-bit fields at bits 16 and 24, and 8-bit counter and timer. It drives only small thresholds and delays, from 0 to 7. This lets the counter wrap, the timer reach zero, and the collisions of completion, expiry and control write each happen within a few cycles. Writing junk into the low control bits shows that the field positions are decoded exactly. Holding `tick_en` low for stretches separates timer gating from counting.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  // Per-cycle action selected for the packet counter
  typedef enum logic [1:0] {
    CNT_HOLD,
    CNT_LOAD,
    CNT_DEC,
    CNT_WRAP
  } cnt_act_e;
endpackage

// File: rtl/coal_field_dec.sv
module coal_field_dec #(
  parameter int CTRL_W  = 32,
  parameter int THR_LSB = 16,
  parameter int DLY_LSB = 24,
  parameter int CNT_W   = 8,
  parameter int DLY_W   = 8
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [CNT_W-1:0]  thr_o,
  output logic [DLY_W-1:0]  dly_o,
  output logic              dly_zero_o
);
  logic [CNT_W-1:0] thr_raw;
  logic             unused_ctrl;

  assign thr_raw     = ctrl_i[THR_LSB +: CNT_W];
  // A zero threshold would never wrap; treat it as one
  assign thr_o       = (thr_raw == '0) ? CNT_W'(1) : thr_raw;
  assign dly_o       = ctrl_i[DLY_LSB +: DLY_W];
  assign dly_zero_o  = (dly_o == '0);
  assign unused_ctrl = ^ctrl_i;
endmodule

// File: rtl/coal_delay_timer.sv
module coal_delay_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [DLY_W-1:0] tmr_o,
  output logic             expire_o,
  output logic             dly_pulse_o
);
  logic [DLY_W-1:0] tmr_q;
  logic             pulse_q;

  // Expiry is the 1 -> 0 step, unless a restart overrides it
  assign expire_o = !load_i && tick_i && (tmr_q == DLY_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= expire_o;
      if (load_i)
        tmr_q <= load_val_i;
      else if (tick_i && (tmr_q != '0))
        tmr_q <= tmr_q - DLY_W'(1);
    end
  end

  assign tmr_o       = tmr_q;
  assign dly_pulse_o = pulse_q;
endmodule

// File: rtl/coal_pkt_counter.sv
module coal_pkt_counter
  import irq_coal_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload_i,
  input  logic             done_i,
  input  logic             expire_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ioc_pulse_o
);
  cnt_act_e         act;
  logic [CNT_W-1:0] cnt_q;
  logic             ioc_q;

  // Priority: control write, then completion, then timer expiry
  always_comb begin
    if (reload_i)
      act = CNT_LOAD;
    else if (done_i)
      act = (cnt_q <= CNT_W'(1)) ? CNT_WRAP : CNT_DEC;
    else if (expire_i)
      act = CNT_LOAD;
    else
      act = CNT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(1);
      ioc_q <= 1'b0;
    end else begin
      ioc_q <= (act == CNT_WRAP);
      case (act)
        CNT_LOAD: cnt_q <= thr_i;
        CNT_WRAP: cnt_q <= thr_i;
        CNT_DEC:  cnt_q <= cnt_q - CNT_W'(1);
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o       = cnt_q;
  assign ioc_pulse_o = ioc_q;
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
  parameter int CTRL_W  = 32,
  parameter int THR_LSB = 16,
  parameter int DLY_LSB = 24,
  parameter int CNT_W   = 8,
  parameter int DLY_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_done,
  input  logic              tick_en,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              ioc_set,
  output logic              dly_set,
  output logic [CNT_W-1:0]  coal_cnt,
  output logic [DLY_W-1:0]  delay_cnt
);
  logic [CNT_W-1:0] thr;
  logic [DLY_W-1:0] dly;
  logic             dly_zero;
  logic             tmr_load;
  logic             tmr_expire;

  coal_field_dec #(
    .CTRL_W(CTRL_W), .THR_LSB(THR_LSB), .DLY_LSB(DLY_LSB),
    .CNT_W(CNT_W), .DLY_W(DLY_W)
  ) u_dec (
    .ctrl_i(ctrl_word), .thr_o(thr), .dly_o(dly), .dly_zero_o(dly_zero)
  );

  assign tmr_load = pkt_done && !dly_zero;

  coal_delay_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk(clk), .rst(rst), .load_i(tmr_load), .load_val_i(dly),
    .tick_i(tick_en), .tmr_o(delay_cnt), .expire_o(tmr_expire),
    .dly_pulse_o(dly_set)
  );

  coal_pkt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .reload_i(ctrl_wr), .done_i(pkt_done),
    .expire_i(tmr_expire), .thr_i(thr), .cnt_o(coal_cnt),
    .ioc_pulse_o(ioc_set)
  );
endmodule

// File: rtl/irq_coalescer_chk.sv
module irq_coalescer_chk #(
  parameter int CTRL_W  = 32,
  parameter int THR_LSB = 16,
  parameter int DLY_LSB = 24,
  parameter int CNT_W   = 8,
  parameter int DLY_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pkt_done,
  input logic              tick_en,
  input logic              ctrl_wr,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              ioc_set,
  input logic              dly_set,
  input logic [CNT_W-1:0]  coal_cnt,
  input logic [DLY_W-1:0]  delay_cnt
);
  logic [CNT_W-1:0] thr_f;
  logic [DLY_W-1:0] dly_f;
  assign thr_f = (ctrl_word[THR_LSB +: CNT_W] == '0) ? CNT_W'(1)
                                                      : ctrl_word[THR_LSB +: CNT_W];
  assign dly_f = ctrl_word[DLY_LSB +: DLY_W];

  a_r3_cnt_nonzero: assert property (@(posedge clk) disable iff (rst)
    coal_cnt != '0);

  a_r3_ioc_reloads: assert property (@(posedge clk) disable iff (rst)
    ioc_set |-> coal_cnt == $past(thr_f));

  a_r5_timer_load: assert property (@(posedge clk) disable iff (rst)
    (pkt_done && dly_f != '0) |=> delay_cnt == $past(dly_f));

  a_r6_zero_delay_hold: assert property (@(posedge clk) disable iff (rst)
    (pkt_done && dly_f == '0 && !tick_en) |=> $stable(delay_cnt));

  a_r7_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (!pkt_done && !tick_en) |=> $stable(delay_cnt));

  a_r8_expiry_at_zero: assert property (@(posedge clk) disable iff (rst)
    dly_set |-> delay_cnt == '0);

  a_r8_expiry_reload: assert property (@(posedge clk) disable iff (rst)
    (dly_set && !$past(pkt_done) && !$past(ctrl_wr)) |-> coal_cnt == $past(thr_f));
endmodule

bind irq_coalescer irq_coalescer_chk #(
  .CTRL_W(CTRL_W), .THR_LSB(THR_LSB), .DLY_LSB(DLY_LSB),
  .CNT_W(CNT_W), .DLY_W(DLY_W)
) chk_i (
  .clk(clk), .rst(rst), .pkt_done(pkt_done), .tick_en(tick_en),
  .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word), .ioc_set(ioc_set),
  .dly_set(dly_set), .coal_cnt(coal_cnt), .delay_cnt(delay_cnt)
);

// File: tb/irq_coalescer_tb_top.sv
module irq_coalescer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pkt_done = 1'b0;
  logic        tick_en = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic        ioc_set, dly_set;
  logic [7:0]  coal_cnt, delay_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_coalescer dut_i (
    .clk(clk), .rst(rst), .pkt_done(pkt_done), .tick_en(tick_en),
    .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word), .ioc_set(ioc_set),
    .dly_set(dly_set), .coal_cnt(coal_cnt), .delay_cnt(delay_cnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Apply one cycle of stimulus, then return at the following negedge
  task automatic step(input logic pd, input logic wr, input logic tk);
    pkt_done = pd; ctrl_wr = wr; tick_en = tk;
    @(posedge clk);
    @(negedge clk);
    pkt_done = 1'b0; ctrl_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic expect_state(input string req, input int c, input int t, input int i, input int d);
    chk(req, "coal_cnt", int'(coal_cnt), c);
    chk(req, "delay_cnt", int'(delay_cnt), t);
    chk(req, "ioc_set", int'(ioc_set), i);
    chk(req, "dly_set", int'(dly_set), d);
  endtask

  function automatic logic [31:0] cw(input int dly, input int thr);
    return {8'(dly), 8'(thr), 16'hA5C3};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_state("R1", 1, 0, 0, 0);
    rst = 1'b0;
    step(0, 0, 0);
    expect_state("R1", 1, 0, 0, 0);
  endtask

  task automatic t_count();
    ctrl_word = cw(0, 3);
    step(0, 1, 0); expect_state("R2", 3, 0, 0, 0);
    step(1, 0, 0); expect_state("R3", 2, 0, 0, 0);
    step(1, 0, 0); expect_state("R3", 1, 0, 0, 0);
    step(1, 0, 0); expect_state("R3", 3, 0, 1, 0);
    step(0, 0, 0); expect_state("R11", 3, 0, 0, 0);
  endtask

  task automatic t_thr_zero();
    ctrl_word = cw(0, 0);
    step(0, 1, 0); expect_state("R4", 1, 0, 0, 0);
    step(1, 0, 0); expect_state("R4", 1, 0, 1, 0);
    step(1, 0, 0); expect_state("R4", 1, 0, 1, 0);
    step(0, 0, 0); expect_state("R11", 1, 0, 0, 0);
  endtask

  task automatic t_delay();
    ctrl_word = cw(5, 4);
    step(0, 1, 0); expect_state("R9", 4, 0, 0, 0);
    step(1, 0, 1); expect_state("R5", 3, 5, 0, 0);
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 0); expect_state("R7", 3, 5, 0, 0);
    end
    for (int k = 4; k >= 1; k--) begin
      step(0, 0, 1); expect_state("R7", 3, k, 0, 0);
    end
    step(0, 0, 1); expect_state("R8", 4, 0, 0, 1);
    step(0, 0, 1); expect_state("R7", 4, 0, 0, 0);
    step(1, 0, 1); expect_state("R5", 3, 5, 0, 0);
    step(0, 0, 1); step(0, 0, 1); expect_state("R7", 3, 3, 0, 0);
    step(1, 0, 1); expect_state("R5", 2, 5, 0, 0);
    for (int k = 0; k < 5; k++) step(0, 0, 1);
    expect_state("R8", 4, 0, 0, 1);
  endtask

  task automatic t_zero_delay();
    ctrl_word = cw(3, 4);
    step(0, 1, 0);
    step(1, 0, 1); expect_state("R5", 3, 3, 0, 0);
    ctrl_word = cw(0, 4);
    step(1, 0, 1); expect_state("R6", 2, 2, 0, 0);
    step(1, 0, 0); expect_state("R6", 1, 2, 0, 0);
    step(0, 0, 1); expect_state("R6", 1, 1, 0, 0);
    step(0, 0, 1); expect_state("R8", 4, 0, 0, 1);
    step(1, 0, 1); expect_state("R6", 3, 0, 0, 0);
    step(0, 0, 1); expect_state("R6", 3, 0, 0, 0);
  endtask

  task automatic t_coincide();
    ctrl_word = cw(2, 4);
    step(0, 1, 0);
    step(1, 0, 1); expect_state("R10", 3, 2, 0, 0);
    step(0, 0, 1); expect_state("R10", 3, 1, 0, 0);
    step(1, 0, 1); expect_state("R10", 2, 2, 0, 0);
    step(0, 0, 1); expect_state("R10", 2, 1, 0, 0);
    step(0, 0, 1); expect_state("R8", 4, 0, 0, 1);
  endtask

  task automatic t_reload_prio();
    ctrl_word = cw(0, 2);
    step(0, 1, 0); expect_state("R9", 2, 0, 0, 0);
    step(1, 0, 0); expect_state("R9", 1, 0, 0, 0);
    step(1, 1, 0); expect_state("R9", 2, 0, 0, 0);
    ctrl_word = cw(0, 7);
    step(0, 1, 0); expect_state("R9", 7, 0, 0, 0);
    ctrl_word = 32'h0000_FFFF;
    step(0, 1, 0); expect_state("R2", 1, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    t_reset();
    t_count();
    t_thr_zero();
    t_delay();
    t_zero_delay();
    t_coincide();
    t_reload_prio();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule